// File: doc/BRIEF.md
# Six-Stage Pixel Colour Combiner with Side Buffer

This block turns the colours that arrive with each pixel (one vertex colour and four texture colours, all 8-bit RGBA) into one final RGBA value. It runs a chain of six combiner stages. Each stage picks two colour operands and two alpha operands from a set of sources. It then applies a small operation to them (replace, modulate or saturating add) and hands its RGBA result to the next stage. The result of the last stage is the pixel's output.

Next to the stage chain there is a side buffer. Any stage can read it as a source. At the start of every pixel it is loaded from a programmable seed colour. After each of the first four stages, its RGB part and its alpha part can each be overwritten with that stage's result, under two separate per-stage mask fields. This lets a later stage reuse an intermediate result that is older than the one just before it. A stage that reads the buffer sees it as the earlier stages of the same pixel left it, never its own update.

Configuration goes through a simple register write port. Pixels flow through a valid/ready stream. The whole chain is evaluated in the cycle a pixel is accepted, and the result is held in a one-entry output register. That register is run by a two-state machine: EMPTY (nothing held) and HOLD (a result waits at the output). Its transitions are: fill (EMPTY to HOLD when a pixel is accepted), refill (HOLD to HOLD when the result leaves and a new pixel enters in the same cycle), stall (HOLD to HOLD while the output is not taken) and drain (HOLD to EMPTY when the result leaves and no pixel enters).

Top module: `combine_stack`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Every register resets to zero, so every stage passes the vertex colour through unchanged.
- R2: A 4-bit source code selects an operand: 0x0 the vertex colour, 0x3/0x4/0x5/0x6 texture colours 0/1/2/3, 0xd the side buffer, 0xe the stage's own constant colour, 0xf the previous stage's result (zero for stage 0). All other codes give zero.
- R3: Stage control word (addresses 0..5 for stages 0..5) fields: colour operand A in bits 3:0, colour operand B in bits 7:4, alpha operand A in bits 11:8, alpha operand B in bits 15:12, colour op in bits 17:16, alpha op in bits 19:18. Op codes: 0 replace (result = A), 1 modulate (floor(A*B/255)), 2 saturating add (min(255, A+B)), 3 replace. The colour op acts on R, G and B of the colour operands; the alpha op acts on A of the alpha operands. Colours are packed as R in bits 7:0, G in 15:8, B in 23:16, A in 31:24. Stage constants sit at addresses 6..11 in the same packing.
- R4: At the start of each pixel the side buffer equals the seed register at address 13 (R 7:0, G 15:8, B 23:16, A 31:24).
- R5: The mask register at address 12 holds an RGB update mask in bits 11:8 and an alpha update mask in bits 15:12, with bit n for stage n. After stage n, the buffer's R, G and B take its result when RGB bit n is set, and the buffer's A takes its result when alpha bit n is set. The two updates are independent.
- R6: Stages 4 and 5 never change the buffer. Writing any other bits of address 12 has no effect.
- R7: A stage that reads the buffer sees it as updated by the earlier stages of the same pixel, not by its own result.
- R8: in_ready equals (not out_valid) or out_ready. An accepted pixel's result is at the output one cycle later. It is held stable while out_ready is 0. Results leave in acceptance order, at up to one per cycle.
- R9: A configuration write affects only pixels accepted after the cycle of the write. A pixel accepted in that same cycle uses the old value. Writes to addresses 14 and 15 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_vtx | input | 32 | Vertex colour, RGBA |
| in_tex | input | 128 | Texture colours 0..3, unit t in bits 32t+31:32t |
| out_valid | output | 1 | Output result valid |
| out_ready | input | 1 | Consumer takes the output |
| out_rgba | output | 32 | Final combined colour |

## Verification
A wrong buffer value cannot be seen at the ports until a later stage selects code 0xd. A fault in the update logic of stage n therefore shows in the output of the same pixel, one cycle after acceptance, but only if some stage after n reads the buffer. The directed cases arrange exactly that for stage 0 with RGB-only and alpha-only masks, for stage 3 with stages 4 and 5 masked on, and for a stage that reads the buffer while updating it. A wrong state in the output machine shows as a result that is dropped, duplicated or changed during a stall, and it is caught at the very next comparison against the ordered list of expected results.

// File: rtl/ccb_pkg.sv
package ccb_pkg;

    typedef logic [31:0] rgba_t;

    typedef enum logic [1:0] {
        OP_REPL  = 2'd0,
        OP_MOD   = 2'd1,
        OP_ADD   = 2'd2,
        OP_REPL2 = 2'd3
    } op_e;

    // Stage control word, 20 bits, LSB first: colour A, colour B, alpha A, alpha B, ops
    typedef struct packed {
        op_e        aop;
        op_e        cop;
        logic [3:0] asb;
        logic [3:0] asa;
        logic [3:0] csb;
        logic [3:0] csa;
    } stage_cfg_t;

    localparam logic [3:0] SRC_VTX   = 4'h0;
    localparam logic [3:0] SRC_TEX0  = 4'h3;
    localparam logic [3:0] SRC_BUF   = 4'hd;
    localparam logic [3:0] SRC_CONST = 4'he;
    localparam logic [3:0] SRC_PREV  = 4'hf;

    localparam int MASK_RGB_LSB = 8;
    localparam int MASK_A_LSB   = 12;

    function automatic logic [7:0] chan_op(op_e op, logic [7:0] a, logic [7:0] b);
        logic [15:0] prod;
        logic [8:0]  sum;
        logic [7:0]  r;
        prod = 16'(a) * 16'(b);
        sum  = 9'(a) + 9'(b);
        case (op)
            OP_MOD:  r = 8'(prod / 16'd255);
            OP_ADD:  r = sum[8] ? 8'hFF : sum[7:0];
            default: r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ccb_cfg.sv
module ccb_cfg
    import ccb_pkg::*;
#(
    parameter int NSTAGE = 6,
    parameter int NUPD   = 4,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output stage_cfg_t        stage_cfg [NSTAGE],
    output rgba_t             stage_k   [NSTAGE],
    output logic [NUPD-1:0]   mask_rgb,
    output logic [NUPD-1:0]   mask_a,
    output rgba_t             seed
);

    localparam int A_K0   = NSTAGE;
    localparam int A_MASK = 2 * NSTAGE;
    localparam int A_SEED = 2 * NSTAGE + 1;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_st
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_cfg[s] <= '0;
                stage_k[s]   <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == AW'(s))
                    stage_cfg[s] <= stage_cfg_t'(cfg_wdata[$bits(stage_cfg_t)-1:0]);
                if (cfg_addr == AW'(A_K0 + s))
                    stage_k[s] <= cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_rgb <= '0;
            mask_a   <= '0;
            seed     <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == AW'(A_MASK)) begin
                mask_rgb <= cfg_wdata[MASK_RGB_LSB +: NUPD];
                mask_a   <= cfg_wdata[MASK_A_LSB +: NUPD];
            end
            if (cfg_addr == AW'(A_SEED))
                seed <= cfg_wdata;
        end
    end

endmodule

// File: rtl/ccb_stage.sv
module ccb_stage
    import ccb_pkg::*;
#(
    parameter int NTEX = 4
) (
    input  stage_cfg_t         cfg,
    input  rgba_t              konst,
    input  rgba_t              vtx,
    input  logic [NTEX*32-1:0] tex,
    input  rgba_t              prev,
    input  rgba_t              buf_in,
    input  logic               upd_rgb,
    input  logic               upd_a,
    output rgba_t              res,
    output rgba_t              buf_out
);

    function automatic rgba_t pick(logic [3:0] code, rgba_t v, rgba_t k, rgba_t p,
                                   rgba_t b, logic [NTEX*32-1:0] t);
        rgba_t r;
        case (code)
            SRC_VTX:   r = v;
            SRC_BUF:   r = b;
            SRC_CONST: r = k;
            SRC_PREV:  r = p;
            default:   r = '0;
        endcase
        for (int i = 0; i < NTEX; i++)
            if (code == 4'(SRC_TEX0 + i))
                r = t[i*32 +: 32];
        return r;
    endfunction

    rgba_t opd_ca, opd_cb, opd_aa, opd_ab;

    always_comb begin
        opd_ca = pick(cfg.csa, vtx, konst, prev, buf_in, tex);
        opd_cb = pick(cfg.csb, vtx, konst, prev, buf_in, tex);
        opd_aa = pick(cfg.asa, vtx, konst, prev, buf_in, tex);
        opd_ab = pick(cfg.asb, vtx, konst, prev, buf_in, tex);
        for (int c = 0; c < 3; c++)
            res[c*8 +: 8] = chan_op(cfg.cop, opd_ca[c*8 +: 8], opd_cb[c*8 +: 8]);
        res[31:24] = chan_op(cfg.aop, opd_aa[31:24], opd_ab[31:24]);
    end

    // buffer leaving this stage: read above uses buf_in, so own update is invisible
    always_comb begin
        buf_out = buf_in;
        if (upd_rgb) buf_out[23:0]  = res[23:0];
        if (upd_a)   buf_out[31:24] = res[31:24];
    end

endmodule

// File: rtl/ccb_ostage.sv
module ccb_ostage
    import ccb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    output logic  in_ready,
    input  rgba_t in_data,
    output logic  out_valid,
    input  logic  out_ready,
    output rgba_t out_data
);

    typedef enum logic {EMPTY = 1'b0, HOLD = 1'b1} ost_e;

    ost_e state, state_nx;
    logic take;

    always_comb begin
        state_nx = state;
        unique case (state)
            EMPTY: if (in_valid) state_nx = HOLD;                // fill
            HOLD:  if (out_ready && !in_valid) state_nx = EMPTY; // drain; else refill or stall
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            EMPTY: begin out_valid = 1'b0; in_ready = 1'b1;      end
            HOLD:  begin out_valid = 1'b1; in_ready = out_ready; end
        endcase
        take = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    out_data <= '0;
        else if (take) out_data <= in_data;
    end

endmodule

// File: rtl/combine_stack.sv
module combine_stack
    import ccb_pkg::*;
#(
    parameter int NSTAGE = 6,
    parameter int NUPD   = 4,
    parameter int NTEX   = 4,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_vtx,
    input  logic [NTEX*32-1:0] in_tex,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_rgba
);

    stage_cfg_t      stage_cfg [NSTAGE];
    rgba_t           stage_k   [NSTAGE];
    logic [NUPD-1:0] mask_rgb, mask_a;
    rgba_t           seed;

    rgba_t resc [NSTAGE+1];
    rgba_t bufc [NSTAGE+1];

    ccb_cfg #(.NSTAGE(NSTAGE), .NUPD(NUPD), .AW(AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .stage_cfg (stage_cfg),
        .stage_k   (stage_k),
        .mask_rgb  (mask_rgb),
        .mask_a    (mask_a),
        .seed      (seed)
    );

    assign resc[0] = '0;
    assign bufc[0] = seed;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        logic u_rgb, u_a;
        if (s < NUPD) begin : g_upd
            assign u_rgb = mask_rgb[s];
            assign u_a   = mask_a[s];
        end else begin : g_noupd
            assign u_rgb = 1'b0;
            assign u_a   = 1'b0;
        end

        ccb_stage #(.NTEX(NTEX)) u_st (
            .cfg     (stage_cfg[s]),
            .konst   (stage_k[s]),
            .vtx     (in_vtx),
            .tex     (in_tex),
            .prev    (resc[s]),
            .buf_in  (bufc[s]),
            .upd_rgb (u_rgb),
            .upd_a   (u_a),
            .res     (resc[s+1]),
            .buf_out (bufc[s+1])
        );
    end

    ccb_ostage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (resc[NSTAGE]),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_rgba)
    );

endmodule

// File: rtl/ccb_chk.sv
module ccb_chk #(
    parameter int NUPD = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [31:0]     out_rgba,
    input logic [NUPD-1:0] mask_rgb,
    input logic [NUPD-1:0] mask_a,
    input logic [31:0]     buf_first,
    input logic [31:0]     buf_after0,
    input logic [31:0]     buf_upd_end,
    input logic [31:0]     buf_final
);

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_rgba));

    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);

    p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    p_rgbkeep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_rgb[0] |-> buf_after0[23:0] == buf_first[23:0]);

    p_akeep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_a[0] |-> buf_after0[31:24] == buf_first[31:24]);

    p_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_final == buf_upd_end);

endmodule

bind combine_stack ccb_chk #(.NUPD(NUPD)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_rgba    (out_rgba),
    .mask_rgb    (mask_rgb),
    .mask_a      (mask_a),
    .buf_first   (bufc[0]),
    .buf_after0  (bufc[1]),
    .buf_upd_end (bufc[NUPD]),
    .buf_final   (bufc[NSTAGE])
);

// File: tb/combine_stack_tb_top.sv
module combine_stack_tb_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_we;
    logic [3:0]   cfg_addr;
    logic [31:0]  cfg_wdata;
    logic         in_valid;
    logic         in_ready;
    logic [31:0]  in_vtx;
    logic [127:0] in_tex;
    logic         out_valid;
    logic         out_ready;
    logic [31:0]  out_rgba;

    always #(CLK_PERIOD/2) clk = ~clk;

    combine_stack dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_vtx(in_vtx), .in_tex(in_tex), .out_valid(out_valid),
        .out_ready(out_ready), .out_rgba(out_rgba)
    );

    int total = 0;
    int bad = 0;

    // bench copy of the programmed configuration
    logic [31:0] m_cfg [6];
    logic [31:0] m_k   [6];
    logic [31:0] m_ctl;
    logic [31:0] m_seed;

    logic [31:0] px_vtx;
    logic [31:0] px_tex [4];

    logic [31:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [7:0] mop(logic [1:0] op, logic [7:0] a, logic [7:0] b);
        int r;
        if (op == 2'd1)      r = (int'(a) * int'(b)) / 255;
        else if (op == 2'd2) r = (int'(a) + int'(b) > 255) ? 255 : int'(a) + int'(b);
        else                 r = int'(a);
        return 8'(r);
    endfunction

    function automatic logic [31:0] msel(logic [3:0] code, int s, logic [31:0] prv,
                                         logic [31:0] bf);
        if (code == 4'h0) return px_vtx;
        if (code >= 4'h3 && code <= 4'h6) return px_tex[code - 4'h3];
        if (code == 4'hd) return bf;
        if (code == 4'he) return m_k[s];
        if (code == 4'hf) return prv;
        return 32'h0;
    endfunction

    function automatic logic [31:0] model();
        logic [31:0] prv, bf, o, ca, cb, aa, ab, w;
        prv = 32'h0;
        bf  = m_seed;
        for (int s = 0; s < 6; s++) begin
            w  = m_cfg[s];
            ca = msel(w[3:0], s, prv, bf);
            cb = msel(w[7:4], s, prv, bf);
            aa = msel(w[11:8], s, prv, bf);
            ab = msel(w[15:12], s, prv, bf);
            for (int c = 0; c < 3; c++) o[c*8 +: 8] = mop(w[17:16], ca[c*8 +: 8], cb[c*8 +: 8]);
            o[31:24] = mop(w[19:18], aa[31:24], ab[31:24]);
            if (s < 4) begin
                if (m_ctl[8 + s])  bf[23:0]  = o[23:0];
                if (m_ctl[12 + s]) bf[31:24] = o[31:24];
            end
            prv = o;
        end
        return prv;
    endfunction

    function automatic logic [31:0] scfg(logic [3:0] ca, logic [3:0] cb, logic [3:0] aa,
                                         logic [3:0] ab, logic [1:0] cop, logic [1:0] aop);
        return {12'h0, aop, cop, ab, aa, cb, ca};
    endfunction

    task automatic rnd_px();
        px_vtx = $urandom;
        for (int t = 0; t < 4; t++) px_tex[t] = $urandom;
    endtask

    task automatic step(bit we, logic [3:0] a, logic [31:0] d, bit iv, bit ordy, string tag);
        @(negedge clk);
        cfg_we    = we;
        cfg_addr  = a;
        cfg_wdata = d;
        in_valid  = iv;
        out_ready = ordy;
        in_vtx    = px_vtx;
        in_tex    = {px_tex[3], px_tex[2], px_tex[1], px_tex[0]};
        #1;
        if (out_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R8 unexpected output act=%08h exp=none", out_rgba);
            end else begin
                if (out_rgba !== exp_q[0]) begin
                    bad++;
                    $display("FAIL %s act=%08h exp=%08h", tag_q[0], out_rgba, exp_q[0]);
                end
                if (ordy) begin
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
        if (iv && in_ready) begin
            exp_q.push_back(model());
            tag_q.push_back(tag);
        end
        if (we) begin
            if (a < 4'd6)        m_cfg[a] = d;
            else if (a < 4'd12)  m_k[a - 4'd6] = d;
            else if (a == 4'd12) m_ctl = d;
            else if (a == 4'd13) m_seed = d;
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        step(1'b1, a, d, 1'b0, 1'b1, "cfg");
    endtask

    task automatic px(string tag);
        rnd_px();
        step(1'b0, 4'h0, 32'h0, 1'b1, 1'b1, tag);
    endtask

    task automatic all_prev();
        for (int s = 0; s < 6; s++) wr(4'(s), scfg(4'hf, 4'h0, 4'hf, 4'h0, 2'd0, 2'd0));
    endtask

    task automatic chk(bit cond, string msg, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", msg, act, expv);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R8 watchdog expired act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int s = 0; s < 6; s++) begin m_cfg[s] = 0; m_k[s] = 0; end
        m_ctl = 0; m_seed = 0;
        rnd_px();
        rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        in_valid = 0; out_ready = 1; in_vtx = 0; in_tex = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 1);
        for (int i = 0; i < 3; i++) px("R1 default passes vertex");

        // R2: every source code on colour and alpha, all stages same code
        for (int code = 0; code < 16; code++) begin
            for (int s = 0; s < 6; s++) begin
                wr(4'(s), scfg(4'(code), 4'h0, 4'(code), 4'h0, 2'd0, 2'd0));
                wr(4'(6 + s), $urandom);
            end
            wr(4'd13, $urandom);
            px("R2 source code");
            px("R2 source code");
        end

        // R3: operations with saturation and full-scale modulate corners
        all_prev();
        wr(4'd0, scfg(4'h3, 4'h4, 4'h3, 4'h4, 2'd1, 2'd2));
        rnd_px(); px_tex[0] = 32'hFFFF_FFFF; px_tex[1] = 32'hFFFF_FFFF;
        step(1'b0, 4'h0, 0, 1'b1, 1'b1, "R3 modulate 255 and add saturate");
        rnd_px(); px_tex[0] = 32'h80_40_01_00; px_tex[1] = 32'h80_C0_FF_FF;
        step(1'b0, 4'h0, 0, 1'b1, 1'b1, "R3 modulate low and add carry");
        wr(4'd0, scfg(4'h5, 4'h6, 4'h0, 4'h6, 2'd2, 2'd1));
        for (int i = 0; i < 4; i++) px("R3 add colour modulate alpha");
        wr(4'd0, scfg(4'h3, 4'h4, 4'h3, 4'h4, 2'd3, 2'd3));
        px("R3 op 3 replaces");

        // R4: all stages read the buffer, no updates
        wr(4'd12, 32'h0);
        for (int s = 0; s < 6; s++) wr(4'(s), scfg(4'hd, 4'h0, 4'hd, 4'h0, 2'd0, 2'd0));
        for (int i = 0; i < 3; i++) begin
            wr(4'd13, $urandom);
            px("R4 seed reaches output");
        end

        // R5: RGB-only and alpha-only update from stage 0, read by stage 5
        all_prev();
        wr(4'd0, scfg(4'he, 4'h0, 4'he, 4'h0, 2'd0, 2'd0));
        wr(4'd6, 32'h11223344);
        wr(4'd13, 32'hA5B6C7D8);
        wr(4'd5, scfg(4'hd, 4'h0, 4'hd, 4'h0, 2'd0, 2'd0));
        wr(4'd12, 32'h0000_0100);
        px("R5 rgb-only update");
        wr(4'd12, 32'h0000_1000);
        px("R5 alpha-only update");
        wr(4'd12, 32'h0000_2400);
        wr(4'd2, scfg(4'he, 4'h0, 4'hf, 4'h0, 2'd0, 2'd0));
        wr(4'd8, 32'h99AA_BBCC);
        px("R5 stage2 rgb stage1 alpha");

        // R6: every mask bit set, stages 4 and 5 must not update
        for (int s = 0; s < 5; s++) begin
            wr(4'(s), scfg(4'he, 4'h0, 4'he, 4'h0, 2'd0, 2'd0));
            wr(4'(6 + s), $urandom);
        end
        wr(4'd5, scfg(4'hd, 4'h0, 4'hd, 4'h0, 2'd0, 2'd0));
        wr(4'd12, 32'hFFFF_FFFF);
        px("R6 stage4 write ignored");
        wr(4'd12, 32'hFFFF_00FF);
        px("R6 other mask-register bits ignored");

        // R7: stage 0 reads buffer while updating it
        all_prev();
        wr(4'd12, 32'h0000_1100);
        wr(4'd13, 32'h10203040);
        wr(4'd6, 32'h01020304);
        wr(4'd0, scfg(4'he, 4'hd, 4'he, 4'hd, 2'd2, 2'd2));
        wr(4'd1, scfg(4'hd, 4'hf, 4'hd, 4'hf, 2'd2, 2'd2));
        px("R7 own update not visible");
        px("R7 own update not visible");

        // R9: write in the same cycle as an accept; dead addresses
        for (int s = 0; s < 6; s++) wr(4'(s), scfg(4'hd, 4'h0, 4'hd, 4'h0, 2'd0, 2'd0));
        wr(4'd12, 32'h0);
        rnd_px();
        step(1'b1, 4'd13, 32'hCAFE_F00D, 1'b1, 1'b1, "R9 old seed in write cycle");
        px("R9 new seed after write");
        wr(4'd14, 32'hFFFF_FFFF);
        wr(4'd15, 32'hFFFF_FFFF);
        px("R9 dead address writes");

        // R8: back-pressure, stalls and refills
        for (int i = 0; i < 60; i++) begin
            rnd_px();
            step(1'b0, 4'h0, 0, 1'($urandom % 2), 1'($urandom % 3 != 0), "R8 backpressure");
        end

        // random configuration and traffic
        for (int i = 0; i < 1500; i++) begin
            bit we;
            logic [3:0] a;
            logic [31:0] d;
            we = ($urandom % 4) == 0;
            a  = 4'($urandom % 16);
            d  = $urandom;
            if (a == 4'd12) d = d & 32'h0000_FF00;
            rnd_px();
            step(we, a, d, 1'($urandom % 4 != 0), 1'($urandom % 4 != 0), "R5 random mix");
        end

        // drain
        for (int i = 0; i < 4; i++) step(1'b0, 4'h0, 0, 1'b0, 1'b1, "R8 drain");
        chk(exp_q.size() == 0, "R8 all results delivered", 32'(exp_q.size()), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule